// File: doc/BRIEF.md
# Two-Wire Register File Target with Per-Transaction Pointer Mode

This block is the serial-bus target through which a host configures a bank of 8-bit control registers. It listens on oversampled clock and data lines from the pads. It recognises its 7-bit device address, which a strap pin picks from a pair. It then drives an open-drain pull-down on the data line to acknowledge bytes and to return read data. Each register update is also signalled to the surrounding chip logic on a one-cycle write port. All register contents are presented on a flat output vector.

The first byte after the address in a write carries the register pointer. Its low seven bits are the register index. Its top bit selects the pointer mode for the rest of the access. With the top bit set, the pointer advances after every data byte, for writes and for reads after a repeated START. With it clear, every byte goes to or comes from the same register. A read that opens without a pointer byte starts at the pointer left by the most recent write, and in that write's mode.

Top module: `i2c_regfile_target`

## Requirements
- R1: The device address is 7'b0110100 when `addr_sel_i` is 0 and 7'b0110101 when it is 1. An address byte carries the address in its upper seven bits and the direction in bit 0 (0 write, 1 read). A matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R2: An address byte that does not match is not acknowledged. All following bytes up to the next START are ignored: no acknowledge, no register change.
- R3: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START at any point, including inside a byte, restarts address reception. A STOP returns the block to idle with SDA released.
- R4: Bytes are 8 bits, MSB first, each followed by one acknowledge bit. Every pointer and data byte of an addressed write is acknowledged.
- R5: In a write whose pointer byte has bit 7 set, successive data bytes go to successive registers, starting at the index in bits 6:0.
- R6: In a write whose pointer byte has bit 7 clear, every data byte goes to the same register, and the last one stays.
- R7: A read after a pointer byte with bit 7 set and a repeated START returns successive registers, advancing after each byte sent.
- R8: A read after a pointer byte with bit 7 clear returns the same register for every byte until the master stops.
- R9: A read with no pointer byte starts at the pointer left by the latest write, including its auto-increments, and uses that write's mode. Reads do not move that pointer.
- R10: When the master answers a read byte with NACK (SDA high), the block releases SDA and drives nothing until the next START.
- R11: Register 5 implements only bits 4:0, and its other bits always read 0. After reset, register 6 holds 60h and every other register holds 00h.
- R12: Indices at or above NUM_REGS (default 16) are unmapped. Writes to them are acknowledged but discarded and raise no write strobe. Reads from them return 00h.
- R13: Each stored byte produces exactly one `reg_wr_o` pulse, with the index and the stored (masked) value on `reg_idx_o` and `reg_wdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 1 | Strap choosing the low bit of the device address |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| reg_wr_o | output | 1 | One-cycle pulse for each stored register byte |
| reg_idx_o | output | 7 | Index of the register just written |
| reg_wdata_o | output | 8 | Value just stored |
| regs_o | output | NUM_REGS*8 | All register contents, register k at bits 8k+7:8k |

## Verification
Two events share one bus clock edge in this block. On the falling edge that closes a write data byte, the register store happens and the pointer advances. On the clock edge of a read acknowledge, the pointer for the next byte is chosen and its data is fetched. The bench provokes both with back-to-back multi-byte bursts in each pointer mode. It judges the result by reading the register bank and by comparing each returned byte against the index it should come from. A pointer left by an incrementing write is then reused by a read without a pointer byte. That checks the two pointer copies do not disturb each other.

// File: rtl/i2crf_pkg.sv
package i2crf_pkg;

    localparam int IDX_W  = 7;
    localparam int BYTE_W = 8;

    // upper six bits of the device address; the strap supplies bit 0
    localparam logic [5:0] DEV_ADDR_STEM = 6'b011010;

    // register with a reduced set of implemented bits
    localparam int                NARROW_IDX  = 5;
    localparam logic [BYTE_W-1:0] NARROW_MASK = 8'h1F;

    // register with a non-zero reset value
    localparam int                PRESET_IDX  = 6;
    localparam logic [BYTE_W-1:0] PRESET_VAL  = 8'h60;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } bus_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    typedef struct packed {
        logic              stb;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    function automatic logic [BYTE_W-1:0] reg_mask(input int idx);
        return (idx == NARROW_IDX) ? NARROW_MASK : '1;
    endfunction

    function automatic logic [BYTE_W-1:0] reg_reset(input int idx);
        return (idx == PRESET_IDX) ? PRESET_VAL : '0;
    endfunction

endpackage

// File: rtl/i2crf_line_sync.sv
module i2crf_line_sync
    import i2crf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sync;
    logic [TOP:0] sda_sync;
    logic         scl_q;
    logic         sda_q;
    logic         scl_now;
    logic         sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[TOP-1:0], scl_i};
            sda_sync <= {sda_sync[TOP-1:0], sda_i};
            scl_q    <= scl_sync[TOP];
            sda_q    <= sda_sync[TOP];
        end
    end

    assign scl_now = scl_sync[TOP];
    assign sda_now = sda_sync[TOP];

    always_comb begin
        ev_o.scl_rise = scl_now & ~scl_q;
        ev_o.scl_fall = ~scl_now & scl_q;
        ev_o.start    = scl_now & scl_q & sda_q & ~sda_now;
        ev_o.stop     = scl_now & scl_q & ~sda_q & sda_now;
        ev_o.sda      = sda_now;
    end

endmodule

// File: rtl/i2crf_regbank.sv
module i2crf_regbank
    import i2crf_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  reg_wr_t                    wr_i,
    input  logic [IDX_W-1:0]           rd_idx_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o,
    output reg_wr_t                    wr_o
);

    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    logic              wr_mapped;

    assign wr_mapped = wr_i.stb && (int'(wr_i.idx) < NUM_REGS);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= reg_reset(g);
            end else if (wr_mapped && wr_i.idx == IDX_W'(g)) begin
                regs_q[g] <= wr_i.data & reg_mask(g);
            end
        end
        assign regs_o[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx_i == IDX_W'(k)) rd_data_o = regs_q[k];
        end
    end

    // notification towards chip logic, aligned with the register update
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_o <= '0;
        end else begin
            wr_o.stb  <= wr_mapped;
            wr_o.idx  <= wr_i.idx;
            wr_o.data <= wr_i.data & reg_mask(int'(wr_i.idx));
        end
    end

    // R12: a write outside the bank leaves every register untouched
    a_r12_unmapped_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_i.stb && !wr_mapped) |=> $stable(regs_o));

    // R11: unimplemented bits of the narrow register never read as 1
    a_r11_narrow_bits_zero: assert property (@(posedge clk) disable iff (rst)
        ((regs_q[NARROW_IDX] & ~NARROW_MASK) == '0));

    // R13: the strobe reports exactly what the bank now holds
    a_r13_strobe_matches_bank: assert property (@(posedge clk) disable iff (rst)
        wr_o.stb |-> (regs_o[int'(wr_o.idx)*BYTE_W +: BYTE_W] == wr_o.data));

endmodule

// File: rtl/i2crf_bus_fsm.sv
module i2crf_bus_fsm
    import i2crf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev_i,
    input  logic              addr_sel_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [IDX_W-1:0]  rd_idx_o,
    output reg_wr_t           wr_o,
    output logic              sda_oe_o
);

    bus_state_e        state;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              byte_full;
    logic              is_read;
    logic              inc_mode;
    logic              nack_seen;
    logic [IDX_W-1:0]  wr_ptr;
    logic [IDX_W-1:0]  rd_ptr;
    logic              sda_oe;
    logic [6:0]        own_addr;
    logic              receiving;

    assign own_addr  = {DEV_ADDR_STEM, addr_sel_i};
    assign receiving = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_WDATA);
    assign rd_idx_o  = rd_ptr;
    assign sda_oe_o  = sda_oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            byte_full <= 1'b0;
            is_read   <= 1'b0;
            inc_mode  <= 1'b0;
            nack_seen <= 1'b0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            sda_oe    <= 1'b0;
            wr_o      <= '0;
        end else begin
            wr_o.stb <= 1'b0;
            if (ev_i.start) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                byte_full <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (ev_i.stop) begin
                state     <= ST_IDLE;
                byte_full <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (receiving) begin
                if (ev_i.scl_rise && !byte_full) begin
                    rx_sh   <= {rx_sh[BYTE_W-2:0], ev_i.sda};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) byte_full <= 1'b1;
                end else if (ev_i.scl_fall && byte_full) begin
                    byte_full <= 1'b0;
                    unique case (state)
                        ST_ADDR: begin
                            if (rx_sh[7:1] == own_addr) begin
                                is_read <= rx_sh[0];
                                rd_ptr  <= wr_ptr;
                                sda_oe  <= 1'b1;
                                state   <= ST_ADDR_ACK;
                            end else begin
                                state   <= ST_IDLE;
                            end
                        end
                        ST_SUB: begin
                            wr_ptr   <= rx_sh[IDX_W-1:0];
                            inc_mode <= rx_sh[7];
                            sda_oe   <= 1'b1;
                            state    <= ST_SUB_ACK;
                        end
                        default: begin
                            wr_o.stb  <= 1'b1;
                            wr_o.idx  <= wr_ptr;
                            wr_o.data <= rx_sh;
                            if (inc_mode) wr_ptr <= wr_ptr + 1'b1;
                            sda_oe    <= 1'b1;
                            state     <= ST_WDATA_ACK;
                        end
                    endcase
                end
            end else begin
                unique case (state)
                    ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: begin
                        if (ev_i.scl_fall) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR_ACK && is_read) begin
                                tx_sh  <= rd_data_i;
                                sda_oe <= ~rd_data_i[7];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= (state == ST_ADDR_ACK) ? ST_SUB : ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev_i.scl_fall) begin
                            if (bit_cnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RDATA_ACK;
                            end else begin
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~tx_sh[6];
                                bit_cnt <= bit_cnt + 3'd1;
                            end
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (ev_i.scl_rise) begin
                            nack_seen <= ev_i.sda;
                            if (inc_mode) rd_ptr <= rd_ptr + 1'b1;
                        end else if (ev_i.scl_fall) begin
                            bit_cnt <= '0;
                            if (nack_seen) begin
                                state <= ST_IDLE;
                            end else begin
                                tx_sh  <= rd_data_i;
                                sda_oe <= ~rd_data_i[7];
                                state  <= ST_RDATA;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: any START sends the engine back to address reception
    a_r3_start_restarts: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> (state == ST_ADDR));

    // R3: a STOP leaves the engine idle and the line released
    a_r3_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev_i.stop |=> (state == ST_IDLE && !sda_oe));

    // R2: a foreign address is never acknowledged
    a_r2_foreign_addr_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && ev_i.scl_fall && byte_full && rx_sh[7:1] != own_addr)
        |=> (state == ST_IDLE && !sda_oe));

    // R10: nothing is driven while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R4: the line is pulled only in acknowledge or read-data phases
    a_r4_drive_phases: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state inside {ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK, ST_RDATA}));

    // R5: an incrementing write leaves the pointer one past the byte stored
    a_r5_ptr_advances: assert property (@(posedge clk) disable iff (rst)
        (wr_o.stb && inc_mode) |-> (wr_ptr == wr_o.idx + 1'b1));

    // R6: a fixed-mode write leaves the pointer on the byte stored
    a_r6_ptr_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_o.stb && !inc_mode) |-> (wr_ptr == wr_o.idx));

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2crf_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic                       addr_sel_i,
    output logic                       sda_oe_o,
    output logic                       reg_wr_o,
    output logic [IDX_W-1:0]           reg_idx_o,
    output logic [BYTE_W-1:0]          reg_wdata_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    line_ev_t          line_ev;
    reg_wr_t           fsm_wr;
    reg_wr_t           bank_wr;
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_data;

    i2crf_line_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (line_ev)
    );

    i2crf_bus_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (line_ev),
        .addr_sel_i (addr_sel_i),
        .rd_data_i  (rd_data),
        .rd_idx_o   (rd_idx),
        .wr_o       (fsm_wr),
        .sda_oe_o   (sda_oe_o)
    );

    i2crf_regbank #(
        .NUM_REGS (NUM_REGS)
    ) i_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (fsm_wr),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .regs_o    (regs_o),
        .wr_o      (bank_wr)
    );

    assign reg_wr_o    = bank_wr.stb;
    assign reg_idx_o   = bank_wr.idx;
    assign reg_wdata_o = bank_wr.data;

endmodule

// File: tb/test_i2c_regfile_target.sv
module test_i2c_regfile_target;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 12;
    localparam int NREG       = 16;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             scl_m = 1'b1;
    logic             sda_m = 1'b1;
    logic             addr_sel = 1'b0;
    logic             sda_oe;
    logic             sda_line;
    logic             reg_wr;
    logic [6:0]       reg_idx;
    logic [7:0]       reg_wdata;
    logic [NREG*8-1:0] regs;

    int tests_run    = 0;
    int tests_failed = 0;
    int wr_count     = 0;
    logic [6:0] last_idx  = '0;
    logic [7:0] last_data = '0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regfile_target #(.NUM_REGS(NREG)) i_i2c_regfile_target (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .addr_sel_i  (addr_sel),
        .sda_oe_o    (sda_oe),
        .reg_wr_o    (reg_wr),
        .reg_idx_o   (reg_idx),
        .reg_wdata_o (reg_wdata),
        .regs_o      (regs)
    );

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_count  <= wr_count + 1;
            last_idx  <= reg_idx;
            last_data <= reg_wdata;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] reg_at(input int k);
        return regs[k*8 +: 8];
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wait_clks(HALF/2);
        scl_m = 1'b1; wait_clks(HALF);
        sda_m = 1'b0; wait_clks(HALF);
        scl_m = 1'b0; wait_clks(HALF/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clks(HALF/2);
        scl_m = 1'b1; wait_clks(HALF);
        sda_m = 1'b1; wait_clks(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_clks(HALF/2);
        scl_m = 1'b1; wait_clks(HALF);
        scl_m = 1'b0; wait_clks(HALF/2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_clks(HALF/2);
        scl_m = 1'b1; wait_clks(HALF/2);
        b = sda_line; wait_clks(HALF/2);
        scl_m = 1'b0; wait_clks(HALF/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic write_regs(input logic [7:0] dev, input logic [7:0] sub,
                              input logic [7:0] d0, input logic [7:0] d1,
                              input logic [7:0] d2, input int n, output logic all_ack);
        logic a;
        all_ack = 1'b1;
        bus_start();
        send_byte({dev[6:0], 1'b0}, a); all_ack &= a;
        send_byte(sub, a); all_ack &= a;
        if (n > 0) begin send_byte(d0, a); all_ack &= a; end
        if (n > 1) begin send_byte(d1, a); all_ack &= a; end
        if (n > 2) begin send_byte(d2, a); all_ack &= a; end
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R11 reset reg6", reg_at(6), 8'h60);
        for (int k = 0; k < NREG; k++) if (k != 6) chk("R11 reset zero", reg_at(k), 8'h00);
        chk("R10 released after reset", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic t_write_inc();
        logic ok;
        int c0 = wr_count;
        write_regs(8'h34, 8'h82, 8'hA1, 8'hB2, 8'hC3, 3, ok);
        chk("R1 R4 write acked", {7'b0, ok}, 8'h01);
        chk("R5 reg2", reg_at(2), 8'hA1);
        chk("R5 reg3", reg_at(3), 8'hB2);
        chk("R5 reg4", reg_at(4), 8'hC3);
        chk("R13 strobe count", 8'(wr_count - c0), 8'd3);
        chk("R13 last idx", {1'b0, last_idx}, 8'h04);
        chk("R13 last data", last_data, 8'hC3);
    endtask

    task automatic t_write_fixed();
        logic ok;
        write_regs(8'h34, 8'h08, 8'h11, 8'h22, 8'h33, 3, ok);
        chk("R6 acked", {7'b0, ok}, 8'h01);
        chk("R6 reg8 last", reg_at(8), 8'h33);
        chk("R6 reg9 untouched", reg_at(9), 8'h00);
    endtask

    task automatic t_read_inc();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'h68, a);
        send_byte(8'h82, a);
        bus_start();
        send_byte(8'h69, a);
        chk("R7 read addr ack", {7'b0, a}, 8'h01);
        recv_byte(1'b1, d); chk("R7 byte0", d, 8'hA1);
        recv_byte(1'b1, d); chk("R7 byte1", d, 8'hB2);
        recv_byte(1'b0, d); chk("R7 byte2", d, 8'hC3);
        bus_stop();
    endtask

    task automatic t_read_fixed();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'h68, a);
        send_byte(8'h03, a);
        bus_start();
        send_byte(8'h69, a);
        recv_byte(1'b1, d); chk("R8 byte0", d, 8'hB2);
        recv_byte(1'b1, d); chk("R8 byte1", d, 8'hB2);
        recv_byte(1'b0, d); chk("R8 byte2", d, 8'hB2);
        bus_stop();
    endtask

    task automatic t_masked();
        logic ok, a;
        logic [7:0] d;
        write_regs(8'h34, 8'h05, 8'hFF, 8'h00, 8'h00, 1, ok);
        chk("R11 narrow reg stored", reg_at(5), 8'h1F);
        bus_start();
        send_byte(8'h68, a);
        send_byte(8'h05, a);
        bus_start();
        send_byte(8'h69, a);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R11 narrow reg read", d, 8'h1F);
    endtask

    task automatic t_read_nosub();
        logic ok, a;
        logic [7:0] d;
        write_regs(8'h34, 8'h8C, 8'h77, 8'h00, 8'h00, 1, ok);
        write_regs(8'h34, 8'h8A, 8'h5A, 8'h6B, 8'h00, 2, ok);
        for (int pass = 0; pass < 2; pass++) begin
            bus_start();
            send_byte(8'h69, a);
            recv_byte(1'b1, d); chk("R9 first from write ptr", d, 8'h77);
            recv_byte(1'b0, d); chk("R9 advances in inc mode", d, 8'h00);
            bus_stop();
        end
    endtask

    task automatic t_nack_release();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'h69, a);
        recv_byte(1'b0, d);
        sda_m = 1'b0;
        wait_clks(HALF/2);
        for (int i = 0; i < 3; i++) begin
            wait_clks(4);
            chk("R10 released after nack", {7'b0, sda_oe}, 8'h00);
        end
        scl_m = 1'b1; wait_clks(HALF);
        sda_m = 1'b1; wait_clks(HALF);
        chk("R10 idle after stop", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic t_foreign_addr();
        logic ok;
        logic a;
        bus_start();
        send_byte(8'h6A, a);
        chk("R2 foreign addr no ack", {7'b0, a}, 8'h00);
        send_byte(8'h82, a);
        chk("R2 later byte no ack", {7'b0, a}, 8'h00);
        send_byte(8'hEE, a);
        bus_stop();
        chk("R2 reg2 unchanged", reg_at(2), 8'hA1);
        ok = 1'b0;
        write_regs(8'h34, 8'h01, 8'h0F, 8'h00, 8'h00, 1, ok);
        chk("R2 next START serves again", reg_at(1), 8'h0F);
    endtask

    task automatic t_addr_sel();
        logic ok, a;
        logic [7:0] d;
        addr_sel = 1'b1;
        write_regs(8'h34, 8'h01, 8'h99, 8'h00, 8'h00, 1, ok);
        chk("R1 low addr refused when sel=1", {7'b0, ok}, 8'h00);
        chk("R1 reg1 kept", reg_at(1), 8'h0F);
        write_regs(8'h35, 8'h01, 8'h42, 8'h00, 8'h00, 1, ok);
        chk("R1 high addr acked", {7'b0, ok}, 8'h01);
        bus_start();
        send_byte(8'h6B, a);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R1 read via high addr", d, 8'h42);
        addr_sel = 1'b0;
    endtask

    task automatic t_unmapped();
        logic ok, a;
        logic [7:0] d;
        int c0 = wr_count;
        write_regs(8'h34, 8'h14, 8'h99, 8'h00, 8'h00, 1, ok);
        chk("R12 unmapped write acked", {7'b0, ok}, 8'h01);
        chk("R12 no strobe", 8'(wr_count - c0), 8'd0);
        bus_start();
        send_byte(8'h68, a);
        send_byte(8'h14, a);
        bus_start();
        send_byte(8'h69, a);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R12 unmapped reads zero", d, 8'h00);
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        send_byte(8'h68, a);
        send_byte(8'h8E, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        send_byte(8'h68, a);
        chk("R3 restart mid-byte acked", {7'b0, a}, 8'h01);
        send_byte(8'h0F, a);
        send_byte(8'h4D, a);
        bus_stop();
        chk("R3 partial byte dropped", reg_at(14), 8'h00);
        chk("R3 new access stored", reg_at(15), 8'h4D);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            tests_failed++;
            $display("FAIL watchdog R1-wide run actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        wait_clks(5);
        rst = 1'b0;
        wait_clks(5);
        t_reset();
        t_write_inc();
        t_write_fixed();
        t_read_inc();
        t_read_fixed();
        t_masked();
        t_read_nosub();
        t_nack_release();
        t_foreign_addr();
        t_addr_sel();
        t_unmapped();
        t_restart();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule